// File: doc/BRIEF.md
# Static Memory Read Wait Sequencer

This block runs read cycles on one asynchronous static memory select. A host raises `req_valid` with an address while `req_ready` is high. The sequencer then holds the active-low select low and counts down a programmable number of read wait states. On the final countdown state it captures the memory data bus, releases the select and hands the data back with a one-cycle `ack`. The active-low output enable can be postponed by a programmable number of cycles after the select goes low.

A slow device can stretch the access by pulling the active-low wait pin low. The pin passes through two flip-flops. Its synchronized level is only honoured while the countdown sits at 3, 2 or 1. Each low sample there freezes the countdown for one cycle. Once the synchronized wait is seen high again after at least one stretch, the access is queued to finish: the remaining countdown states run out and later wait pulses are ignored. The number of stretch cycles per access is capped. An access that reaches the cap completes anyway and reports `err_timeout` together with its `ack`.

Top module: `static_read_seq`

## Requirements
- R1: A programmed wait-state count `cfg_wst` below 3 is treated as 3. With no wait stretching, an access holds `mem_cs_n` low for 4 cycles when `cfg_wst` is 0, 1, 2 or 3.
- R2: With the wait pin high throughout, `mem_cs_n` stays low for exactly W+1 consecutive cycles, where W is the effective wait-state count. It goes low in the cycle after the accepting clock edge.
- R3: The level of `mem_wait_n` acts on the countdown three clock edges after it is driven (two synchronizer stages plus the deciding edge). A low level that reaches the countdown while it is above 3 adds no cycles.
- R4: Each synchronized low wait sample that arrives while the countdown is 3, 2 or 1 adds exactly one cycle to the access, and the countdown holds its value during that cycle.
- R5: After the first synchronized high wait sample inside the window that follows at least one stretch cycle, later low wait samples in the same access add no cycles.
- R6: `mem_oe_n` goes low D cycles after `mem_cs_n` goes low, where D is `cfg_oe_dly` clamped to W-1. It is never low while `mem_cs_n` is high, and it rises together with `mem_cs_n`.
- R7: `mem_din` is captured on the final countdown state and presented on `rd_data` while `ack` is high. `ack` is high for exactly one cycle, the cycle after `mem_cs_n` rises.
- R8: `req_ready` is high only when the sequencer is idle. `req_valid` raised during an access starts no further access.
- R9: One access adds at most STRETCH_MAX stretch cycles (default 16365). An access that reaches the cap finishes its countdown and raises `err_timeout` in its `ack` cycle. `err_timeout` is low in every other cycle.
- R10: While reset is held, and after it is released, `mem_cs_n` and `mem_oe_n` are high, `ack` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host read request |
| req_addr | input | AW | Host read address |
| req_ready | output | 1 | High when a request can be accepted |
| ack | output | 1 | One-cycle completion strobe |
| rd_data | output | DW | Captured read data |
| err_timeout | output | 1 | Stretch cap reached, valid with `ack` |
| cfg_wst | input | WSTW | Programmed read wait-state count |
| cfg_oe_dly | input | WSTW | Output-enable delay in cycles |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | AW | Address held for the access |
| mem_din | input | DW | Data bus from the memory |
| mem_wait_n | input | 1 | Active-low wait from the memory |

## Verification
Accesses are run with the wait pin idle, with a wait pulse that ends before the countdown window, with a pulse that covers the window, and with a pulse, a release and a second pulse. These tell ignored samples apart from counted stretch cycles and from samples dropped after the queue point. Wait-state counts below, at and above the minimum separate clamping from the normal countdown. Zero, mid-range and oversized enable delays separate delayed enable from its clamp. A wait held far beyond the cap checks that the access still ends and reports the error. A behavioural model is compared with every output on every cycle, and hand-computed select and enable lengths are checked per access.

// File: rtl/static_read_seq.sv
module static_read_seq #(
  parameter int AW          = 16,
  parameter int DW          = 16,
  parameter int WSTW        = 5,
  parameter int STRETCH_MAX = 16365
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  output logic            req_ready,
  output logic            ack,
  output logic [DW-1:0]   rd_data,
  output logic            err_timeout,
  input  logic [WSTW-1:0] cfg_wst,
  input  logic [WSTW-1:0] cfg_oe_dly,
  output logic            mem_cs_n,
  output logic            mem_oe_n,
  output logic [AW-1:0]   mem_addr,
  input  logic [DW-1:0]   mem_din,
  input  logic            mem_wait_n
);

  localparam int SCW     = $clog2(STRETCH_MAX + 1);
  localparam int WST_MIN = 3;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_DONE} st_t;

  st_t             st;
  logic [WSTW-1:0] cnt, oe_cnt;
  logic [SCW-1:0]  scnt;
  logic            queued, tout;
  logic            ws1, ws2;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   data_q;

  logic [WSTW-1:0] wst_eff, oe_eff;
  logic            win, lowin, stall;

  assign wst_eff = (cfg_wst < WSTW'(WST_MIN)) ? WSTW'(WST_MIN) : cfg_wst;
  assign oe_eff  = (cfg_oe_dly > wst_eff - 1'b1) ? wst_eff - 1'b1 : cfg_oe_dly;

  assign win   = (cnt != '0) && (cnt <= WSTW'(WST_MIN));
  assign lowin = (st == S_ACC) && win && !ws2 && !queued;
  assign stall = lowin && (scnt != SCW'(STRETCH_MAX));

  assign req_ready   = (st == S_IDLE);
  assign ack         = (st == S_DONE);
  assign err_timeout = (st == S_DONE) && tout;
  assign mem_cs_n    = (st != S_ACC);
  assign mem_oe_n    = !((st == S_ACC) && (oe_cnt == '0));
  assign mem_addr    = addr_q;
  assign rd_data     = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      oe_cnt <= '0;
      scnt   <= '0;
      queued <= 1'b0;
      tout   <= 1'b0;
      ws1    <= 1'b1;
      ws2    <= 1'b1;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      ws1 <= mem_wait_n;
      ws2 <= ws1;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            st     <= S_ACC;
            addr_q <= req_addr;
            cnt    <= wst_eff;
            oe_cnt <= oe_eff;
            scnt   <= '0;
            queued <= 1'b0;
            tout   <= 1'b0;
          end
        end
        S_ACC: begin
          if (oe_cnt != '0) oe_cnt <= oe_cnt - 1'b1;
          if (stall) begin
            scnt <= scnt + 1'b1;
          end else begin
            if (lowin) tout <= 1'b1;
            if (cnt == '0) begin
              data_q <= mem_din;
              st     <= S_DONE;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          if (win && ws2 && (scnt != '0)) queued <= 1'b1;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_MIN_COUNT:   assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_cs_n) |-> cnt >= WSTW'(WST_MIN)); // R1
  AST_FREEZE:      assert property (@(posedge clk) disable iff (!rst_n) stall |=> $stable(cnt)); // R4
  AST_OE_IN_CS:    assert property (@(posedge clk) disable iff (!rst_n) !mem_oe_n |-> !mem_cs_n); // R6
  AST_ACK_AFTER:   assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_cs_n) |-> ack); // R7
  AST_ACK_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R7
  AST_BUSY_READY:  assert property (@(posedge clk) disable iff (!rst_n) !mem_cs_n |-> !req_ready); // R8
  AST_STRETCH_CAP: assert property (@(posedge clk) disable iff (!rst_n) scnt <= SCW'(STRETCH_MAX)); // R9
  AST_ERR_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n) err_timeout |-> ack); // R9

endmodule

// File: tb/sim_static_read_seq.sv
module sim_static_read_seq;
  localparam int AW = 16, DW = 16, WSTW = 5, SMAX = 16365;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_ready, ack, err_timeout, mem_cs_n, mem_oe_n;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] mem_din = '0;
  logic [AW-1:0] mem_addr;
  logic [WSTW-1:0] cfg_wst = 5'd3, cfg_oe_dly = '0;
  logic mem_wait_n = 1'b1;

  int n_run = 0, n_fail = 0, cyc = 0;
  string cur_req = "R10";

  static_read_seq #(.AW(AW), .DW(DW), .WSTW(WSTW), .STRETCH_MAX(SMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .ack(ack), .rd_data(rd_data), .err_timeout(err_timeout),
    .cfg_wst(cfg_wst), .cfg_oe_dly(cfg_oe_dly), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_din(mem_din), .mem_wait_n(mem_wait_n));

  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 reading, 2 handing back
  int ph = 0, left = 0, oel = 0, str = 0, s1 = 1, s2 = 1;
  bit q = 0, to = 0;
  int m_addr = 0, m_data = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; left = 0; oel = 0; str = 0; s1 = 1; s2 = 1; q = 0; to = 0;
    end else begin
      if (ph == 0) begin
        if (req_valid) begin
          ph = 1;
          left = (cfg_wst < 3) ? 3 : int'(cfg_wst);
          oel = (int'(cfg_oe_dly) > left - 1) ? left - 1 : int'(cfg_oe_dly);
          str = 0; q = 0; to = 0;
          m_addr = int'(req_addr);
        end
      end else if (ph == 1) begin
        bit inw, lo, hold;
        inw = (left >= 1) && (left <= 3);
        lo = inw && (s2 == 0) && !q;
        hold = lo && (str < SMAX);
        if (oel > 0) oel--;
        if (inw && s2 == 1 && str > 0) q = 1;
        if (hold) str++;
        else begin
          if (lo) to = 1;
          if (left == 0) begin m_data = int'(mem_din); ph = 2; end
          else left--;
        end
      end else ph = 0;
      s2 = s1;
      s1 = int'(mem_wait_n);
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(cur_req, "cs_n model", int'(mem_cs_n), int'(ph != 1));
      check(cur_req, "oe_n model", int'(mem_oe_n), int'(!(ph == 1 && oel == 0)));
      check("R8", "ready model", int'(req_ready), int'(ph == 0));
      check("R7", "ack model", int'(ack), int'(ph == 2));
      check("R9", "err model", int'(err_timeout), int'(ph == 2 && to));
      if (ph == 2) check("R7", "rd_data model", int'(rd_data), m_data);
      if (ph == 1) check(cur_req, "addr model", int'(mem_addr), m_addr);
    end
    if (cyc > 190000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic run(input string req, input int wst, input int oed,
                     input int b1, input int l1, input int b2, input int l2,
                     input int dat, input int exp_err, output int csl, output int oel_n);
    int k;
    bit done;
    cur_req = req;
    cfg_wst = WSTW'(wst);
    cfg_oe_dly = WSTW'(oed);
    mem_din = DW'(dat);
    req_addr = req_addr + 16'h0101;
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    csl = 0; oel_n = 0; k = 0; done = 0;
    while (!done) begin
      mem_wait_n = !((k >= b1 && k < b1 + l1) || (k >= b2 && k < b2 + l2));
      req_valid = (k == 2);
      if (k == 2) check("R8", "ready while busy", int'(req_ready), 0);
      if (!mem_cs_n) csl++;
      if (!mem_oe_n) oel_n++;
      if (ack) begin
        done = 1;
        check("R7", "rd_data at ack", int'(rd_data), dat);
        check("R9", "err_timeout at ack", int'(err_timeout), exp_err);
      end
      @(negedge clk);
      k++;
    end
    mem_wait_n = 1'b1;
    req_valid = 1'b0;
    check("R7", "ack one cycle", int'(ack), 0);
    for (int i = 0; i < 4; i++) begin
      check("R8", "no access from busy request", int'(mem_cs_n), 1);
      @(negedge clk);
    end
  endtask

  initial begin
    int c, o;
    repeat (3) @(negedge clk);
    check("R10", "cs_n in reset", int'(mem_cs_n), 1);
    check("R10", "ack in reset", int'(ack), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "cs_n after reset", int'(mem_cs_n), 1);
    check("R10", "oe_n after reset", int'(mem_oe_n), 1);
    check("R10", "ready after reset", int'(req_ready), 1);
    check("R10", "ack after reset", int'(ack), 0);

    run("R2", 5, 0, 0, 0, 0, 0, 16'h1234, 0, c, o);
    check("R2", "cs low cycles W=5", c, 6);
    check("R6", "oe low cycles delay 0", o, 6);
    run("R2", 12, 0, 0, 0, 0, 0, 16'hBEEF, 0, c, o);
    check("R2", "cs low cycles W=12", c, 13);
    run("R1", 1, 0, 0, 0, 0, 0, 16'h0F0F, 0, c, o);
    check("R1", "cs low cycles W=1 clamped", c, 4);
    run("R1", 0, 0, 0, 0, 0, 0, 16'h00FF, 0, c, o);
    check("R1", "cs low cycles W=0 clamped", c, 4);
    run("R3", 8, 0, 0, 2, 0, 0, 16'hA5A5, 0, c, o);
    check("R3", "early wait ignored", c, 9);
    run("R4", 5, 0, 0, 6, 0, 0, 16'h5A5A, 0, c, o);
    check("R4", "six stretch cycles", c, 12);
    run("R5", 5, 0, 0, 4, 6, 20, 16'hC3C3, 0, c, o);
    check("R5", "wait after release ignored", c, 10);
    run("R6", 6, 2, 0, 0, 0, 0, 16'h7777, 0, c, o);
    check("R6", "cs low W=6", c, 7);
    check("R6", "oe low with delay 2", o, 5);
    run("R6", 6, 9, 0, 0, 0, 0, 16'h8888, 0, c, o);
    check("R6", "oe low with delay clamped", o, 2);
    run("R9", 3, 0, 0, 20000, 0, 0, 16'h4321, 1, c, o);
    check("R9", "cs low at stretch cap", c, 4 + SMAX);
    run("R9", 4, 0, 0, 0, 0, 0, 16'h1111, 0, c, o);
    check("R9", "error clears next access", c, 5);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule